// File: doc/BRIEF.md
# Voltmeter Conversion Handshake Sequencer

This block runs one digital-voltmeter reading at a time between a host and an external analog-to-digital converter. A host request makes the sequencer emit a single-cycle start strobe to the converter and then wait for the converter's done signal. The wait is bounded by a limit set on an input port; if the converter stays silent for that many cycles, the attempt is abandoned and a timeout strobe is raised.

Once done is seen, the sequencer turns on the converter's output drivers and steers a readout buffer, which is shared with a frequency counter, into voltmeter mode. It holds both for a settling cycle, samples the 10-bit magnitude together with a sign bit that arrives from a separate rectifier stage, and then releases both. The captured reading is presented as a two's-complement value with a one-cycle valid strobe. When AC mode is selected with the request, the rectified average is converted to an RMS estimate by a factor of 284/256. A parameter can leave this scaling out.

Top module: `dvm_conv_seq`

## Requirements
- R1: After reset, conv_start_o, conv_oe_o, buf_vm_o, busy_o, rd_valid_o and timeout_o are 0, and rd_val_o is 0.
- R2: A request sampled while the block is idle makes conv_start_o high for exactly one cycle, in the cycle right after the sampling edge.
- R3: After the start cycle the block waits up to N cycles for conv_done_i, where N is wait_limit_i and a value of 0 counts as 1. A done seen in any of those N cycles is accepted.
- R4: If conv_done_i is not seen in the N wait cycles, timeout_o is high for one cycle, the cycle after the last wait cycle. No valid strobe is produced, rd_val_o keeps its previous value, and the block returns to idle.
- R5: In the two cycles after the cycle in which conv_done_i is accepted, conv_oe_o and buf_vm_o are both high. The data inputs are sampled at the end of the second of these cycles.
- R6: In the cycle after the sample edge, conv_oe_o and buf_vm_o are both low and rd_valid_o is high for that one cycle only.
- R7: rd_val_o is an 11-bit two's-complement value. It equals minus the magnitude when sign_neg_i was 1 at sampling and plus the magnitude otherwise, so a zero magnitude reads as 0 with either sign. It holds until the next capture.
- R8: With RMS_EN=1 and ac_mode_i high on the accepted request, the magnitude is min(1023, (raw*284 + 128) >> 8). With ac_mode_i low, the magnitude is the raw converter word.
- R9: A request that arrives while busy_o is high is ignored. It causes no extra start strobe and no extra result.
- R10: busy_o is high from the start cycle up to and including the last cycle of the sequence. It is low in the cycle that carries rd_valid_o or timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request for a reading |
| ac_mode_i | input | 1 | AC mode, sampled with the request |
| wait_limit_i | input | TW | Maximum number of cycles to wait for done (0 acts as 1) |
| conv_start_o | output | 1 | Start strobe to the converter |
| conv_done_i | input | 1 | Converter conversion-complete |
| conv_oe_o | output | 1 | Converter output-driver enable |
| buf_vm_o | output | 1 | Shared readout buffer in voltmeter mode |
| conv_mag_i | input | MAG_W | Converter magnitude word |
| sign_neg_i | input | 1 | Sign from the rectifier stage, 1 = negative |
| busy_o | output | 1 | Sequence in progress |
| rd_valid_o | output | 1 | One-cycle strobe, new reading on rd_val_o |
| rd_val_o | output | MAG_W+1 | Signed reading |
| timeout_o | output | 1 | One-cycle strobe, converter did not answer |

## Verification
The bench builds the block with TW=6 and RMS_EN=1, so limits from 0 up to the top value of 63 can all be tried in a short run. It puts done on the last accepted wait cycle, and it also runs attempts where done never comes. The magnitude input carries a garbage pattern whenever the drivers or the buffer mode are off, so a capture at the wrong moment shows up in the value. With scaling built in, the AC cases reach the saturation edge between raw words 922 and 923, as well as full scale with a negative sign.

// File: rtl/dvm_seq_pkg.sv
package dvm_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_ENABLE,
    ST_SAMPLE
  } seq_state_e;

  // average-to-RMS factor 1.11 ~= 284/256
  localparam int unsigned RMS_NUM   = 284;
  localparam int unsigned RMS_SHIFT = 8;
endpackage

// File: rtl/dvm_wait_timer.sv
module dvm_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_eff;
  logic [TW:0]   nxt;

  assign lim_eff  = (limit_i == '0) ? TW'(1) : limit_i;
  assign nxt      = {1'b0, cnt_q} + (TW+1)'(1);
  assign expire_o = run_i && ({1'b0, lim_eff} <= nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= nxt[TW-1:0];
  end
endmodule

// File: rtl/dvm_rms_scale.sv
module dvm_rms_scale
  import dvm_seq_pkg::*;
#(
  parameter int MAG_W  = 10,
  parameter bit RMS_EN = 1'b1
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic             ac_i,
  output logic [MAG_W-1:0] mag_o
);
  localparam int PW = MAG_W + 10;

  generate
    if (RMS_EN) begin : g_scale
      logic [PW-1:0] prod;
      logic [PW-1:0] shf;
      logic [MAG_W-1:0] sat;
      assign prod  = PW'(mag_i) * PW'(RMS_NUM) + PW'(1 << (RMS_SHIFT - 1));
      assign shf   = prod >> RMS_SHIFT;
      assign sat   = (|shf[PW-1:MAG_W]) ? '1 : shf[MAG_W-1:0];
      assign mag_o = ac_i ? sat : mag_i;
    end else begin : g_pass
      logic unused_ac;
      assign unused_ac = ac_i;
      assign mag_o     = mag_i;
    end
  endgenerate
endmodule

// File: rtl/dvm_capture.sv
module dvm_capture #(
  parameter int MAG_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [MAG_W-1:0]        mag_i,
  input  logic                    neg_i,
  output logic signed [MAG_W:0]   val_o
);
  logic signed [MAG_W:0] pos;
  assign pos = $signed({1'b0, mag_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (load_i) val_o <= neg_i ? -pos : pos;
  end
endmodule

// File: rtl/dvm_conv_seq.sv
module dvm_conv_seq
  import dvm_seq_pkg::*;
#(
  parameter int MAG_W  = 10,
  parameter int TW     = 16,
  parameter bit RMS_EN = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  ac_mode_i,
  input  logic [TW-1:0]         wait_limit_i,
  output logic                  conv_start_o,
  input  logic                  conv_done_i,
  output logic                  conv_oe_o,
  output logic                  buf_vm_o,
  input  logic [MAG_W-1:0]      conv_mag_i,
  input  logic                  sign_neg_i,
  output logic                  busy_o,
  output logic                  rd_valid_o,
  output logic signed [MAG_W:0] rd_val_o,
  output logic                  timeout_o
);
  seq_state_e st_q, st_d;
  logic ac_q, expire, valid_q, to_q;
  logic [MAG_W-1:0] mag_s;

  dvm_wait_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (st_q == ST_WAIT),
    .limit_i  (wait_limit_i),
    .expire_o (expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = ST_PULSE;
      ST_PULSE:  st_d = ST_WAIT;
      ST_WAIT:   if (conv_done_i) st_d = ST_ENABLE;
                 else if (expire) st_d = ST_IDLE;
      ST_ENABLE: st_d = ST_SAMPLE;
      ST_SAMPLE: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ac_q    <= 1'b0;
      valid_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      if (st_q == ST_IDLE && req_i) ac_q <= ac_mode_i;
      valid_q <= (st_q == ST_SAMPLE);
      to_q    <= (st_q == ST_WAIT) && !conv_done_i && expire;
    end
  end

  dvm_rms_scale #(.MAG_W(MAG_W), .RMS_EN(RMS_EN)) u_scale (
    .mag_i (conv_mag_i),
    .ac_i  (ac_q),
    .mag_o (mag_s)
  );

  dvm_capture #(.MAG_W(MAG_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st_q == ST_SAMPLE),
    .mag_i  (mag_s),
    .neg_i  (sign_neg_i),
    .val_o  (rd_val_o)
  );

  assign conv_start_o = (st_q == ST_PULSE);
  assign conv_oe_o    = (st_q == ST_ENABLE) || (st_q == ST_SAMPLE);
  assign buf_vm_o     = conv_oe_o;
  assign busy_o       = (st_q != ST_IDLE);
  assign rd_valid_o   = valid_q;
  assign timeout_o    = to_q;
endmodule

// File: rtl/dvm_conv_seq_chk.sv
module dvm_conv_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic conv_done_i,
  input logic conv_start_o,
  input logic conv_oe_o,
  input logic buf_vm_o,
  input logic busy_o,
  input logic rd_valid_o,
  input logic timeout_o
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R2
  AST_START_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_start_o) |-> $past(req_i) && !$past(busy_o)); // R2
  AST_BUSY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> !conv_start_o); // R9
  AST_OE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_oe_o) |-> $past(conv_done_i)); // R5
  AST_VM_WITH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_vm_o) |-> $past(busy_o) && !$past(conv_start_o)); // R5
  AST_VALID_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(conv_oe_o) && !conv_oe_o && !buf_vm_o); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R6
  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R4
  AST_TIMEOUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !rd_valid_o && !busy_o && !conv_oe_o); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o || timeout_o) |-> $past(busy_o) && !busy_o); // R10
endmodule

bind dvm_conv_seq dvm_conv_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .conv_done_i  (conv_done_i),
  .conv_start_o (conv_start_o),
  .conv_oe_o    (conv_oe_o),
  .buf_vm_o     (buf_vm_o),
  .busy_o       (busy_o),
  .rd_valid_o   (rd_valid_o),
  .timeout_o    (timeout_o)
);

// File: tb/dvm_conv_seq_bench.sv
module dvm_conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 10;
  localparam int TW = 6;

  typedef struct packed {
    logic                   to;
    logic signed [MW:0]     val;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, ac = 1'b0, done = 1'b0, sgn = 1'b0;
  logic [TW-1:0] lim = '0;
  logic [MW-1:0] cur_mag = '0, mag_bus;
  logic start, oe, vm, busy, valid, tout;
  logic signed [MW:0] val;

  int total = 0, bad = 0, starts = 0;
  exp_t q[$];
  logic signed [MW:0] last_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter drives garbage unless drivers and buffer mode are on
  assign mag_bus = (oe && vm) ? cur_mag : 10'h155;

  dvm_conv_seq #(.MAG_W(MW), .TW(TW), .RMS_EN(1'b1)) u_dvm_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ac_mode_i(ac),
    .wait_limit_i(lim), .conv_start_o(start), .conv_done_i(done),
    .conv_oe_o(oe), .buf_vm_o(vm), .conv_mag_i(mag_bus),
    .sign_neg_i(sgn), .busy_o(busy), .rd_valid_o(valid),
    .rd_val_o(val), .timeout_o(tout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mag(input int m, input bit a);
    int r;
    if (!a) return m;
    r = (m * 284 + 128) / 256;
    return (r > 1023) ? 1023 : r;
  endfunction

  // monitor: pop expected item on every result or timeout strobe
  always @(negedge clk) begin
    if (rst_n && (valid || tout)) begin
      if (q.size() == 0) chk(1'b0, "R9 unexpected result", int'(val), -9999);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(tout == e.to, "R4 result kind (timeout flag)", int'(tout), int'(e.to));
        chk(val == e.val, e.to ? "R7 value held over timeout" : "R7/R8 reading",
            int'(val), int'(e.val));
        chk(!busy, "R10 busy low on result cycle", int'(busy), 0);
      end
    end
    if (rst_n && start) starts++;
  end

  task automatic conv(input int d, input int m, input bit s, input bit a,
                      input int l, input bit to, input bit poke);
    exp_t e;
    int s0, leff;
    leff = (l == 0) ? 1 : l;
    lim = TW'(l); ac = a; cur_mag = MW'(m); sgn = s;
    e.to = to;
    if (to) e.val = last_val;
    else begin
      e.val = s ? -(MW+1)'(exp_mag(m, a)) : (MW+1)'(exp_mag(m, a));
      last_val = e.val;
    end
    q.push_back(e);
    s0 = starts;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = poke;
    chk(start == 1'b1, "R2 start strobe after request", int'(start), 1);
    chk(busy == 1'b1, "R10 busy in start cycle", int'(busy), 1);
    if (to) begin
      repeat (leff) @(negedge clk) req = 1'b0;
      @(negedge clk);
      chk(tout == 1'b1, "R4 timeout strobe", int'(tout), 1);
      chk(valid == 1'b0, "R4 no valid on timeout", int'(valid), 0);
    end else begin
      repeat (d) @(negedge clk) req = 1'b0;
      done = 1'b1;
      chk(start == 1'b0 && oe == 1'b0, "R2/R3 waiting, drivers off", int'(oe), 0);
      @(negedge clk); done = 1'b0;
      chk(oe && vm, "R3/R5 drivers and vm mode on after done", int'({oe, vm}), 3);
      @(negedge clk);
      chk(oe && vm, "R5 second enable cycle", int'({oe, vm}), 3);
      @(negedge clk);
      chk(!oe && !vm, "R6 drivers released", int'({oe, vm}), 0);
      chk(valid == 1'b1, "R6 valid strobe", int'(valid), 1);
    end
    @(negedge clk);
    chk(valid == 1'b0 && tout == 1'b0, "R6/R4 strobes one cycle", int'({valid, tout}), 0);
    chk(starts == s0 + 1, "R9/R2 exactly one start per sequence", starts - s0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(!start && !oe && !vm && !busy && !valid && !tout, "R1 reset outputs",
        int'({start, oe, vm, busy, valid, tout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(val == 0 && !busy, "R1 reset reading", int'(val), 0);
    conv(1, 300, 0, 0, 5, 0, 0);     // R3 early done
    conv(5, 512, 1, 0, 5, 0, 0);     // R3 done on last wait cycle
    conv(0, 0, 0, 0, 5, 1, 0);       // R4 timeout, value held
    conv(1, 77, 1, 0, 0, 0, 0);      // R3 limit 0 acts as 1
    conv(0, 0, 0, 0, 0, 1, 0);       // R4 timeout after one cycle
    conv(3, 100, 0, 1, 8, 0, 0);     // R8 AC scale
    conv(2, 922, 0, 1, 8, 0, 0);     // R8 last unsaturated
    conv(2, 923, 0, 1, 8, 0, 0);     // R8 saturates
    conv(2, 1023, 1, 1, 8, 0, 0);    // R8 full scale negative
    conv(2, 0, 1, 0, 8, 0, 0);       // R7 zero with sign
    conv(4, 640, 1, 0, 8, 0, 1);     // R9 request while busy ignored
    conv(63, 5, 0, 0, 63, 0, 0);     // R3 top limit
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 all results seen", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule